// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Register Control

This block is a host-programmed I2C bus master. A host drives it through five 8-bit registers, using single-cycle writes and combinational reads. The host does not issue commands. It changes bits in the control register, and each change has a side effect on the bus. Raising the master bit produces a START. Dropping it produces a STOP. Asking for a repeated start while still master re-addresses the bus without a STOP in between.

A write to the data register in transmit mode sends one byte. A read of the data register in receive mode returns the byte received last and starts the next one. For that reason the first read after entering receive mode is a dummy read. After every byte (eight data bits plus the acknowledge slot) the controller holds SCL low and sets a pending flag. The bus then stays parked until the host acts.

SCL and SDA are open-drain. Each has a drive-low enable output and a separate line input. While SCL is released, the bit timer counts only when the SCL line input reads high, so a target can stretch the clock.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset every register reads 0x00, both drive-low enables are 0 and irq is 0.
- R2: Register offsets are: own address at 0 (7-bit address in bits 7:1, bit 0 reads 0), divider at 1, control at 2, status at 3 and data at 4. In the control register, bit 7 enables the block, bit 6 enables the interrupt, bit 5 selects master, bit 4 selects transmit, bit 3 selects NACK, and bit 2 requests a repeated start; bit 2 always reads back 0.
- R3: With the block enabled and idle, setting the master bit makes SDA fall while SCL is released (a START), and status bit 5 (busy) reads 1 from the next cycle on.
- R4: In transmit mode, a data-register write shifts the byte out MSB first and then releases SDA for the acknowledge slot. The SDA level sampled during that slot is stored in status bit 0, where 1 means the target did not acknowledge.
- R5: After the ninth SCL pulse, status bit 1 (pending) and status bit 7 (byte done) are set and SCL is held low. The irq output is high while both the pending bit and control bit 6 are 1.
- R6: Writing the status register with bit 1 at 0 clears the pending bit. Writing bit 1 at 1 leaves it unchanged.
- R7: In receive mode, a data-register read returns the byte that was last completed and starts the next reception. The first read after switching to receive therefore returns the older value.
- R8: In the acknowledge slot of a received byte, the controller drives SDA low when control bit 3 is 0 and leaves it released (NACK) when bit 3 is 1.
- R9: Clearing the master bit while the bus is parked makes SDA rise while SCL is released (a STOP), and the busy bit returns to 0.
- R10: Writing control bit 2 together with the master bit while already master produces a new START with no STOP in between.
- R11: The SCL half period is (code+1)×8 clock cycles, where code is divider bits 5:0. Divider bits 7:6 have no effect.
- R12: Clearing control bit 7 aborts any activity. The cycle after the write, both lines are released and status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data register only) |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Drive SCL low when 1 |
| scl_i | input | 1 | SCL line level |
| sda_oe | output | 1 | Drive SDA low when 1 |
| sda_i | input | 1 | SDA line level |

## Verification
The assertions rely on three things about the inputs:
- The host does not change the NACK select bit during an acknowledge slot that is in progress.
- A status clear does not land in the same cycle as a byte completion.
- The line inputs follow the wired-AND of the drives.

The bench meets all three. It models the bus as a wired-AND of the controller drive and a target model. The target moves SDA only while SCL is low. All register changes are made while the controller is parked after a byte, except for the deliberate abort, during which bus decoding is switched off.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int DIV_MULT = 8,
  parameter int HOLD     = 5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_i,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int CW = $clog2(64 * DIV_MULT) + 1;
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_WAIT = 3'd2,
                         S_XFER = 3'd3, S_RSTRT = 3'd4, S_STOP = 3'd5;
  localparam logic [2:0] A_OWN = 3'd0, A_DIV = 3'd1, A_CTL = 3'd2,
                         A_STS = 3'd3, A_DAT = 3'd4;

  logic [6:0]    own;
  logic [5:0]    div;
  logic          ien, iien, msta, mtx, txak, rsta_req;
  logic          iif, icf, rxak, dir_tx;
  logic [7:0]    shreg, rx_data;
  logic [2:0]    st;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt, half, lim;
  logic          ibb, counting, hold_ph, go, done, dat_wr, dat_rd;

  assign ibb      = st != S_IDLE;
  assign half     = CW'((div + 7'd1) * DIV_MULT);
  assign hold_ph  = st == S_START || (st == S_RSTRT && ph == 2'd2) || (st == S_STOP && ph == 2'd1);
  assign lim      = hold_ph ? CW'(HOLD) : half;
  assign counting = st inside {S_START, S_XFER, S_RSTRT, S_STOP};
  assign scl_oe   = st == S_WAIT || (ph == 2'd0 && st inside {S_XFER, S_RSTRT, S_STOP});
  assign go       = scl_oe | scl_i;
  assign done     = counting && go && cnt == lim - 1'b1;
  assign irq      = iif & iien;
  assign dat_wr   = wr_en && addr == A_DAT;
  assign dat_rd   = rd_en && addr == A_DAT;

  always_comb
    case (st)
      S_START, S_WAIT, S_STOP: sda_oe = 1'b1;
      S_XFER:  sda_oe = bitn[3] ? (!dir_tx && !txak) : (dir_tx && !shreg[7]);
      S_RSTRT: sda_oe = ph == 2'd2;
      default: sda_oe = 1'b0;
    endcase

  always_comb
    case (addr)
      A_OWN:   rdata = {own, 1'b0};
      A_DIV:   rdata = {2'b00, div};
      A_CTL:   rdata = {ien, iien, msta, mtx, txak, 3'b000};
      A_STS:   rdata = {icf, 1'b0, ibb, 3'b000, iif, rxak};
      A_DAT:   rdata = rx_data;
      default: rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own <= '0; div <= '0;
      {ien, iien, msta, mtx, txak, rsta_req} <= '0;
      {iif, icf, rxak, dir_tx} <= '0;
      shreg <= '0; rx_data <= '0;
      st <= S_IDLE; ph <= '0; bitn <= '0; cnt <= '0;
    end else begin
      if (wr_en && addr == A_STS && !wdata[1]) iif <= 1'b0;
      if (counting && go) cnt <= done ? '0 : cnt + 1'b1;
      if (!ien) begin
        st <= S_IDLE; ph <= '0; cnt <= '0;
        iif <= 1'b0; icf <= 1'b0; rxak <= 1'b0; msta <= 1'b0; rsta_req <= 1'b0;
      end else
        case (st)
          S_IDLE:  if (msta) st <= S_START;
          S_START: if (done) st <= S_WAIT;
          S_WAIT:
            if (!msta) begin
              st <= S_STOP; ph <= '0;
            end else if (rsta_req) begin
              st <= S_RSTRT; ph <= '0; rsta_req <= 1'b0;
            end else if (dat_wr && mtx) begin
              shreg <= wdata; dir_tx <= 1'b1; bitn <= '0; ph <= '0; icf <= 1'b0; st <= S_XFER;
            end else if (dat_rd && !mtx) begin
              dir_tx <= 1'b0; bitn <= '0; ph <= '0; icf <= 1'b0; st <= S_XFER;
            end
          S_XFER:
            if (done) begin
              if (ph == 2'd0) ph <= 2'd1;
              else begin
                ph <= 2'd0;
                if (!bitn[3]) begin
                  shreg <= {shreg[6:0], sda_i};
                  bitn  <= bitn + 1'b1;
                end else begin
                  st <= S_WAIT; iif <= 1'b1; icf <= 1'b1;
                  if (dir_tx) rxak <= sda_i;
                  else rx_data <= shreg;
                end
              end
            end
          S_RSTRT:
            if (done) begin
              if (ph == 2'd2) begin st <= S_WAIT; ph <= '0; end
              else ph <= ph + 1'b1;
            end
          S_STOP:
            if (done) begin
              if (ph == 2'd1) begin st <= S_IDLE; ph <= '0; end
              else ph <= 2'd1;
            end
          default: st <= S_IDLE;
        endcase
      if (wr_en)
        case (addr)
          A_OWN: own <= wdata[7:1];
          A_DIV: div <= wdata[5:0];
          A_CTL: begin
            {ien, iien, msta, mtx, txak} <= wdata[7:3];
            rsta_req <= wdata[2] & wdata[5] & msta;
          end
          default: ;
        endcase
    end
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ien,
  input logic       iif,
  input logic       ibb,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [2:0] st,
  input logic [7:0] wdata
);
  localparam logic [2:0] C_XFER = 3'd3;

  AST_START_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibb) |-> sda_oe && !scl_oe); // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibb) |-> !sda_oe && !scl_oe); // R9

  AST_PARK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iif) && ien) |-> scl_oe); // R5

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_XFER && $past(st) == C_XFER && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R4

  AST_DISABLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |=> !scl_oe && !sda_oe && !iif); // R12

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !wdata[1] && st != C_XFER) |=> !iif); // R6
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien(ien), .iif(iif), .ibb(ibb),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en), .addr(addr),
  .st(st), .wdata(wdata)
);

// File: tb/i2c_reg_master_test.sv
module i2c_reg_master_test;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe, scl_l, sda_l, slv_sda;
  logic       slave_rd = 1'b0, slave_ack = 1'b1, mon_en = 1'b1;
  logic [7:0] slave_byte = '0;
  int         drv_idx = 0, last_hi = 0, total = 0, fails = 0;
  bit         finished = 1'b0;
  int         exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  assign slv_sda = slave_rd ? (drv_idx < 8 && !slave_byte[3'(7 - drv_idx)])
                            : (drv_idx == 8 && slave_ack);
  assign scl_l = !scl_oe;
  assign sda_l = !(sda_oe || slv_sda);

  i2c_reg_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_oe(scl_oe), .scl_i(scl_l),
    .sda_oe(sda_oe), .sda_i(sda_l)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int item, input string req);
    exp_q.push_back(item);
    req_q.push_back(req);
  endtask

  task automatic got(input int item);
    if (exp_q.size() == 0) check(1'b0, "unexpected bus event", item, 0);
    else begin
      int e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(item == e, r, item, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (!irq && t < 5000) begin @(negedge clk); t++; end
    check(irq, req, irq, 1);
  endtask

  // Monitor: decodes the bus and compares against the scoreboard queue
  initial begin
    bit pscl, psda;
    int bc, sh, ack, hi;
    pscl = 1'b1; psda = 1'b1; bc = 0; sh = 0; ack = 0; hi = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || !mon_en) begin
        bc = 0; sh = 0; hi = 0; pscl = scl_l; psda = sda_l;
        continue;
      end
      if (scl_l) hi++;
      if (pscl && scl_l && psda && !sda_l) begin bc = 0; sh = 0; got(-1); end
      else if (pscl && scl_l && !psda && sda_l) begin bc = 0; sh = 0; got(-2); end
      else if (!pscl && scl_l) begin
        if (bc < 8) sh = sh * 2 + int'(sda_l);
        else ack = int'(sda_l);
        bc++;
        if (bc == 9) begin got(sh * 2 + ack); bc = 0; sh = 0; end
      end else if (pscl && !scl_l) begin
        last_hi = hi; hi = 0; drv_idx = bc;
      end
      pscl = scl_l; psda = sda_l;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3); rst_n = 1'b1; idle(1);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check(v == 8'h00, "R1 register reset", v, 0);
    end
    check(!scl_oe && !sda_oe && !irq, "R1 lines and irq", {scl_oe, sda_oe, irq}, 0);

    wr(3'd0, 8'hD5); rd(3'd0, v); check(v == 8'hD4, "R2 own address", v, 8'hD4);
    wr(3'd1, 8'hC7); rd(3'd1, v); check(v == 8'h07, "R11 divider upper bits", v, 8'h07);
    wr(3'd2, 8'hDC); rd(3'd2, v); check(v == 8'hD8, "R2 control readback", v, 8'hD8);
    wr(3'd1, 8'h00); wr(3'd2, 8'hD0);

    push(-1, "R3 start");
    wr(3'd2, 8'hF0); rd(3'd3, v); check(v == 8'h20, "R3 busy", v, 8'h20);
    idle(20);
    push(8'hA0 * 2, "R4 address byte acked");
    wr(3'd4, 8'hA0); wait_irq("R5 irq after byte");
    rd(3'd3, v); check(v == 8'hA2, "R5 status after byte", v, 8'hA2);
    check(scl_oe, "R5 SCL parked low", scl_oe, 1);
    wr(3'd3, 8'h02); rd(3'd3, v); check(v == 8'hA2, "R6 write one keeps flag", v, 8'hA2);
    wr(3'd3, 8'h00); rd(3'd3, v); check(v == 8'hA0, "R6 clear flag", v, 8'hA0);
    check(!irq, "R6 irq drops", irq, 0);
    check(last_hi == 8, "R11 half period code 0", last_hi, 8);

    slave_ack = 1'b0;
    push(8'h3C * 2 + 1, "R4 data byte not acked");
    wr(3'd4, 8'h3C); wait_irq("R4 irq");
    rd(3'd3, v); check(v == 8'hA3, "R4 received nack bit", v, 8'hA3);
    wr(3'd3, 8'h00); slave_ack = 1'b1;

    push(-1, "R10 repeated start without stop");
    wr(3'd2, 8'hF4); idle(40);
    rd(3'd2, v); check(v == 8'hF0, "R10 request bit reads 0", v, 8'hF0);
    push(8'hA1 * 2, "R10 read address byte");
    wr(3'd4, 8'hA1); wait_irq("R10 irq"); wr(3'd3, 8'h00);

    slave_rd = 1'b1; slave_byte = 8'h5A;
    wr(3'd2, 8'hE0);
    push(8'h5A * 2, "R8 ack driven");
    rd(3'd4, v); check(v == 8'h00, "R7 dummy read stale", v, 0);
    wait_irq("R7 irq"); wr(3'd3, 8'h00);
    slave_byte = 8'h96;
    wr(3'd2, 8'hE8);
    push(8'h96 * 2 + 1, "R8 nack driven");
    rd(3'd4, v); check(v == 8'h5A, "R7 first byte", v, 8'h5A);
    wait_irq("R7 irq"); wr(3'd3, 8'h00);
    slave_rd = 1'b0;

    push(-2, "R9 stop");
    wr(3'd2, 8'hC0);
    rd(3'd4, v); check(v == 8'h96, "R7 last byte", v, 8'h96);
    idle(40);
    rd(3'd3, v); check(v == 8'h80, "R9 busy cleared", v, 8'h80);

    wr(3'd1, 8'h43);
    push(-1, "R3 start");
    wr(3'd2, 8'hF0); idle(20);
    push(8'hA0 * 2, "R11 byte at code 3");
    wr(3'd4, 8'hA0); wait_irq("R11 irq");
    check(last_hi == 32, "R11 half period code 3", last_hi, 32);
    wr(3'd3, 8'h00);

    mon_en = 1'b0;
    wr(3'd4, 8'h77); idle(100);
    wr(3'd2, 8'h00);
    check(!scl_oe && !sda_oe, "R12 lines released", {scl_oe, sda_oe}, 0);
    rd(3'd3, v); check(v == 8'h00, "R12 status cleared", v, 0);
    rd(3'd2, v); check(v == 8'h00, "R12 control cleared", v, 0);
    idle(5);
    check(exp_q.size() == 0, "R9 all expected bus events seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule